// File: doc/BRIEF.md
# Dual-Resource Requesting Client with Wait Watchdog

This block is a synthesizable client that competes with other clients for two shared resources, called A and B. Each resource has its own plain request/grant pair. After a short pseudo-random idle gap, the client draws two independent random bits that decide whether it wants A, B, both or neither. It raises the chosen requests together. It then waits for the grants one at a time in a fixed order: A first, then B.

Two such clients can sit behind arbiters that favour them in opposite ways. In that case each client may hold one resource while waiting for the other, and neither can proceed. A watchdog bounds every wait to break this. If the awaited grant does not come in time, the client drops both requests, pulses `timeout_pulse` and starts over with a fresh gap. When every requested grant has been seen, the client keeps its requests up for a fixed hold time, then releases them and pulses `done_pulse`.

The grant and request pins are level control signals with no data and no back-pressure. A grant is only sampled on the clock edges where the client is waiting for that particular grant.

Top module: `dual_res_client`

## Requirements
- R1: When a cycle ends (done or timeout), and also after an empty draw, both requests stay low for 1, 2 or 3 cycles before the next draw; the length is pseudo-random, and every one of the three lengths occurs.
- R2: A draw takes two bits from a 16-bit Galois LFSR (right shift, tap mask 0xB400, stepping every clock): one bit for A, one for B, chosen independently. Both request outputs change together from the all-low state and then stay constant until the cycle ends. A-only, B-only and both-requested draws all occur. An empty draw gives no pulse.
- R3: The grant for A is awaited first when A is requested; the grant for B is awaited only after that. While A is awaited, `gnt_b` has no effect, even if it is held high.
- R4: Let the requests rise visibly after edge k. A grant sampled high at edge k+d, with 1 <= d <= WAIT_LIMIT (default 17), ends that wait. If no such grant arrives, both requests drop at edge k+WAIT_LIMIT and `timeout_pulse` is high for exactly the one cycle in which they first read low. The next cycle then starts with a gap, as in R1.
- R5: `timeout_pulse` and `done_pulse` are never high together. Requests only fall in a cycle where one of the two pulses is high (reset excepted).
- R6: The watchdog restarts from zero at the start of each wait. After the A grant at edge g, the B wait has its own window: B may be granted up to edge g+WAIT_LIMIT, or the requests time out at that edge. No request stays high longer than 2*WAIT_LIMIT+HOLD_CYCLES cycles.
- R7: The SEED parameter sets the initial LFSR state, and a seed of zero is replaced by 0xACE1. A zero seed therefore behaves exactly like 0xACE1, and a different nonzero seed gives a different request sequence.
- R8: The last awaited grant is sampled at edge g. The requests stay high until edge g+HOLD_CYCLES, where both drop and `done_pulse` is high for that one cycle.
- R9: A grant sampled on the same edge at which the watchdog would expire counts as success, not as a timeout.
- R10: Reset is synchronous and active high. It clears both requests and both pulses by the next edge and reloads the LFSR from the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gnt_a | input | 1 | Grant level for resource A |
| gnt_b | input | 1 | Grant level for resource B |
| req_a | output | 1 | Request for resource A |
| req_b | output | 1 | Request for resource B |
| timeout_pulse | output | 1 | One-cycle strobe when a wait is abandoned |
| done_pulse | output | 1 | One-cycle strobe when a cycle completes normally |

## Verification
The hardest situations to reach from the pins are a grant that lands exactly on the expiry edge, and a B wait that times out after an A grant that arrived late. Both depend on the random draw and on an edge count measured from the request rise. The driver therefore watches for each rise, reads which requests were drawn, and then places single-cycle grant pulses at computed offsets from that rise. The offsets follow a rotating set of patterns: immediate, mid-window, exactly on the limit, one past the limit, a late A grant followed by a missing B grant, and `gnt_b` held high throughout with no A grant. For every cycle the driver queues the pulse kind and latency that the requirements predict.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    ST_GAP    = 2'd0,
    ST_WAIT_A = 2'd1,
    ST_WAIT_B = 2'd2,
    ST_HOLD   = 2'd3
  } drc_state_e;

  // one pseudo-random draw: remaining gap count and the two request picks
  typedef struct packed {
    logic [1:0] gap;
    logic       pick_a;
    logic       pick_b;
  } drc_draw_t;

endpackage

// File: rtl/drc_lfsr.sv
module drc_lfsr
  import drc_pkg::*;
#(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] TAPS     = 16'hB400,
  parameter logic [W-1:0] SEED     = 16'h0001,
  parameter logic [W-1:0] FALLBACK = 16'hACE1,
  parameter int unsigned  BIT_A    = 7,
  parameter int unsigned  BIT_B    = 11
) (
  input  logic      clk,
  input  logic      rst,
  output drc_draw_t draw
);
  localparam logic [W-1:0] START = (SEED == '0) ? FALLBACK : SEED;

  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) state <= START;
    else     state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end

  // gap count 0..2 means 1..3 idle cycles; code 3 folds onto 0
  always_comb begin
    draw.gap    = (state[1:0] == 2'b11) ? 2'b00 : state[1:0];
    draw.pick_a = state[BIT_A];
    draw.pick_b = state[BIT_B];
  end
endmodule

// File: rtl/drc_wdog.sv
module drc_wdog #(
  parameter int unsigned LIMIT = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hit,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || hit || expire) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dual_res_client.sv
module dual_res_client
  import drc_pkg::*;
#(
  parameter logic [15:0] SEED        = 16'h0001,
  parameter int unsigned WAIT_LIMIT  = 17,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gnt_a,
  input  logic gnt_b,
  output logic req_a,
  output logic req_b,
  output logic timeout_pulse,
  output logic done_pulse
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  drc_state_e    state;
  drc_draw_t     draw;
  logic [1:0]    gap_cnt;
  logic [HW-1:0] hold_cnt;
  logic          waiting;
  logic          got;
  logic          expire;

  drc_lfsr #(.W(16), .SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .draw (draw)
  );

  assign waiting = (state == ST_WAIT_A) || (state == ST_WAIT_B);
  assign got     = (state == ST_WAIT_A) ? gnt_a :
                   (state == ST_WAIT_B) ? gnt_b : 1'b0;

  drc_wdog #(.LIMIT(WAIT_LIMIT)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run    (waiting),
    .hit    (got),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    timeout_pulse <= 1'b0;
    done_pulse    <= 1'b0;
    if (rst) begin
      state    <= ST_GAP;
      gap_cnt  <= '0;
      hold_cnt <= '0;
      req_a    <= 1'b0;
      req_b    <= 1'b0;
    end else begin
      unique case (state)
        ST_GAP: begin
          if (gap_cnt == 2'd0) begin
            req_a <= draw.pick_a;
            req_b <= draw.pick_b;
            if (draw.pick_a)      state <= ST_WAIT_A;
            else if (draw.pick_b) state <= ST_WAIT_B;
            else                  gap_cnt <= draw.gap;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_WAIT_A, ST_WAIT_B: begin
          // a grant on the expiry edge wins over the timeout
          if (got) begin
            hold_cnt <= '0;
            state    <= (state == ST_WAIT_A && req_b) ? ST_WAIT_B : ST_HOLD;
          end else if (expire) begin
            req_a         <= 1'b0;
            req_b         <= 1'b0;
            timeout_pulse <= 1'b1;
            gap_cnt       <= draw.gap;
            state         <= ST_GAP;
          end
        end
        ST_HOLD: begin
          if (hold_cnt == HW'(HOLD_CYCLES - 1)) begin
            req_a      <= 1'b0;
            req_b      <= 1'b0;
            done_pulse <= 1'b1;
            gap_cnt    <= draw.gap;
            state      <= ST_GAP;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_res_client_chk.sv
module dual_res_client_chk #(
  parameter int unsigned WAIT_LIMIT  = 17,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic req_a,
  input logic req_b,
  input logic timeout_pulse,
  input logic done_pulse
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 busy_cnt <= 0;
    else if (req_a || req_b) busy_cnt <= busy_cnt + 1;
    else                     busy_cnt <= 0;
  end

  a_r5_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({timeout_pulse, done_pulse}));

  a_r4_drop_on_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> (!req_a && !req_b && $past(req_a || req_b)));

  a_r8_drop_on_done: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (!req_a && !req_b && $past(req_a || req_b)));

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_a) || $rose(req_b)) |-> $past(!req_a && !req_b));

  a_r5_fall_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    (($fell(req_a) || $fell(req_b)) && !$past(rst)) |-> (timeout_pulse || done_pulse));

  a_r6_bounded_busy: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= int'(2 * WAIT_LIMIT + HOLD_CYCLES));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!req_a && !req_b && !timeout_pulse && !done_pulse));
endmodule

bind dual_res_client dual_res_client_chk #(
  .WAIT_LIMIT  (WAIT_LIMIT),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_a         (req_a),
  .req_b         (req_b),
  .timeout_pulse (timeout_pulse),
  .done_pulse    (done_pulse)
);

// File: tb/dual_res_client_bench.sv
module dual_res_client_bench;
  localparam int WL = 17;
  localparam int HC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt_a = 1'b0;
  logic gnt_b = 1'b0;
  logic one = 1'b1;
  logic req_a, req_b, timeout_pulse, done_pulse;
  logic z_a, z_b, z_t, z_d;
  logic r_a, r_b, r_t, r_d;
  logic s_a, s_b, s_t, s_d;

  always #5 clk = ~clk;

  dual_res_client #(.SEED(16'h5A3C), .WAIT_LIMIT(WL), .HOLD_CYCLES(HC)) u_dual_res_client (
    .clk(clk), .rst(rst), .gnt_a(gnt_a), .gnt_b(gnt_b),
    .req_a(req_a), .req_b(req_b), .timeout_pulse(timeout_pulse), .done_pulse(done_pulse));

  // seed twins for R7, all grants tied high
  dual_res_client #(.SEED(16'h0000), .WAIT_LIMIT(WL), .HOLD_CYCLES(HC)) u_seed_zero (
    .clk(clk), .rst(rst), .gnt_a(one), .gnt_b(one),
    .req_a(z_a), .req_b(z_b), .timeout_pulse(z_t), .done_pulse(z_d));
  dual_res_client #(.SEED(16'hACE1), .WAIT_LIMIT(WL), .HOLD_CYCLES(HC)) u_seed_ref (
    .clk(clk), .rst(rst), .gnt_a(one), .gnt_b(one),
    .req_a(r_a), .req_b(r_b), .timeout_pulse(r_t), .done_pulse(r_d));
  dual_res_client #(.SEED(16'h0001), .WAIT_LIMIT(WL), .HOLD_CYCLES(HC)) u_seed_alt (
    .clk(clk), .rst(rst), .gnt_a(one), .gnt_b(one),
    .req_a(s_a), .req_b(s_b), .timeout_pulse(s_t), .done_pulse(s_d));

  typedef struct {
    bit    to;
    int    lat;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops expectations when a pulse appears
  bit       mon_en = 1'b0;
  bit       prev_any = 1'b0;
  bit       active = 1'b0;
  bit       any_now;
  int       lat = 0;
  bit [1:0] combo;
  exp_t     cur;

  always @(negedge clk) begin
    if (rst || !mon_en) begin
      active   = 1'b0;
      prev_any = 1'b0;
    end else begin
      any_now = req_a || req_b;
      if (any_now && !prev_any) begin
        active = 1'b1;
        lat    = 0;
        combo  = {req_a, req_b};
      end else if (active) begin
        lat++;
      end
      if (active && any_now && ({req_a, req_b} != combo))
        chk(1'b0, "R2", "request bits changed mid-cycle", {req_a, req_b}, combo);
      if (timeout_pulse || done_pulse) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5", "pulse with no cycle expected", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(cur.to == timeout_pulse, cur.tag, "pulse kind (1=timeout)", timeout_pulse, cur.to);
          chk(cur.lat == lat, cur.tag, "cycles from request rise to pulse", lat, cur.lat);
        end
        chk(!any_now, "R5", "requests low in pulse cycle", any_now, 0);
        active = 1'b0;
      end
      prev_any = any_now;
    end
  end

  // R7 twin comparison
  int  twin_mism = 0;
  int  alt_diff  = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if ({z_a, z_b, z_t, z_d} != {r_a, r_b, r_t, r_d}) twin_mism++;
      if ({s_a, s_b} != {r_a, r_b}) alt_diff++;
    end
  end

  int seen_a_only = 0, seen_b_only = 0, seen_both = 0;
  bit seen_gap[4];

  task automatic wait_rise(output int run);
    run = 1;
    forever begin
      @(negedge clk);
      if (req_a || req_b) break;
      run++;
    end
  endtask

  // driver: called at the negedge where the requests first read high
  task automatic run_cycle(input int sc);
    bit    ra, rb, bc;
    int    f, s, f1, s1, ia, ib;
    exp_t  e;
    ra = req_a;
    rb = req_b;
    bc = 1'b0;
    s  = 1;
    case (sc)
      0: begin f = 1;  s = 1;  end
      1: begin f = 5;  s = 9;  end
      2: begin f = 17; s = 17; end
      3: begin f = 18; s = 1;  end
      4: begin f = 3;  s = 18; end
      5: begin f = 99; bc = 1'b1; end
      default: begin f = 16; s = 16; end
    endcase
    if (ra && !rb) seen_a_only++;
    if (!ra && rb) seen_b_only++;
    if (ra && rb)  seen_both++;
    f1 = (bc && !ra) ? 1 : f;
    if (f1 > WL) begin
      e.to = 1'b1; e.lat = WL;
    end else if (ra && rb) begin
      s1 = bc ? 1 : s;
      if (s1 > WL) begin e.to = 1'b1; e.lat = f1 + WL; end
      else         begin e.to = 1'b0; e.lat = f1 + s1 + HC; end
    end else begin
      e.to = 1'b0; e.lat = f1 + HC;
    end
    if (e.to) e.tag = (sc == 5) ? "R3" : (sc == 4) ? "R6" : "R4";
    else      e.tag = (sc == 2) ? "R9" : (sc == 6) ? "R6" : "R8";
    q.push_back(e);
    ia = f - 1;
    ib = ra ? (f + s - 1) : (f - 1);
    for (int t = 0; t < 120; t++) begin
      if (t > 0) begin
        @(negedge clk);
        if (!req_a && !req_b) break;
      end
      gnt_a = ra && (t == ia);
      gnt_b = bc || (rb && (t == ib));
    end
    gnt_a = 1'b0;
    gnt_b = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired, run hung", 1, 0);
    finish_run();
  end

  initial begin
    int run;
    repeat (4) @(negedge clk);
    chk(!req_a && !req_b && !timeout_pulse && !done_pulse, "R10", "outputs during reset",
        {req_a, req_b, timeout_pulse, done_pulse}, 0);
    rst    = 1'b0;
    mon_en = 1'b1;
    wait_rise(run);
    for (int c = 0; c < 63; c++) begin
      run_cycle(c % 7);
      wait_rise(run);
      chk(run >= 1 && run <= 30, "R1", "idle cycles before next request", run, 2);
      if (run <= 3) seen_gap[run] = 1'b1;
    end
    chk(q.size() == 0, "R5", "every cycle ended in a pulse", q.size(), 0);
    // mid-cycle reset: requests are high here
    rst = 1'b1;
    @(negedge clk);
    chk(!req_a && !req_b && !timeout_pulse && !done_pulse, "R10", "outputs after mid-cycle reset",
        {req_a, req_b, timeout_pulse, done_pulse}, 0);
    q.delete();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(seen_gap[1], "R1", "gap of 1 cycle observed", seen_gap[1], 1);
    chk(seen_gap[2], "R1", "gap of 2 cycles observed", seen_gap[2], 1);
    chk(seen_gap[3], "R1", "gap of 3 cycles observed", seen_gap[3], 1);
    chk(seen_a_only > 0, "R2", "A-only draws", seen_a_only, 1);
    chk(seen_b_only > 0, "R2", "B-only draws", seen_b_only, 1);
    chk(seen_both > 0, "R2", "both-resource draws", seen_both, 1);
    chk(twin_mism == 0, "R7", "zero seed matches fallback seed", twin_mism, 0);
    chk(alt_diff > 0, "R7", "other seed gives other sequence", alt_diff, 1);
    finish_run();
  end
endmodule